// File: doc/BRIEF.md
# One-Time-Programmable Byte Store with Mode Decode

This block is a synthesizable stand-in for a byte-wide one-time-programmable memory, meant as a test target on a chip or in a system model. Its pins carry the control of such a memory: an active-low chip select, an active-low output gate, a flag that says the programming supply is present, and a flag that says the high identification voltage sits on one address line. The analog levels are reduced to these flags, and the tri-state data bus is reduced to a data byte plus a drive flag.

A combinational decoder sorts the four control pins into eight modes: read, output-off, standby, program, verify, inhibit, identify and illegal. Stored data can only lose ones. A program pulse ANDs the write byte into the addressed word. Only the synchronous erase input brings a word back to all ones. A small pulse state machine decides whether a chip-select low period counts as a program pulse. Its states are `PS_IDLE`, `PS_COUNT` and `PS_READY`, and its transitions are:

- `start` (idle to count, or to ready when one clock is enough).
- `grow` (count to ready once the minimum length is reached).
- `short` (count to idle when the pulse ends early).
- `commit` (ready to idle with a write).
- `abort` (ready to idle without a write).
- `clear` (any state to idle on erase).

Top module: `otp_byte_store`

## Requirements
- R1: After reset every word reads 0xFF, the pulse machine is idle, and with `sel_n` high the drive flag `q_drive` is 0.
- R2: Read mode is `sel_n`=0, `gate_n`=0, `prog_pwr`=0 and `id_hv`=0. In read mode `q_drive`=1 and `q_data` equals the word at `addr` in the same cycle.
- R3: With `prog_pwr`=0, `sel_n`=1 is standby and `sel_n`=0 with `gate_n`=1 is output-off. In both, `q_drive`=0 whatever the other inputs are, and `q_data`=0x00 whenever `q_drive`=0.
- R4: With `prog_pwr`=1 and `id_hv`=0, each mode sets the outputs as follows:
  - `sel_n`=1, `gate_n`=0 is verify: the addressed word is driven.
  - `sel_n`=1, `gate_n`=1 is inhibit: the bus is undriven.
  - `sel_n`=0, `gate_n`=1 is program: the bus is undriven.
- R5: A program pulse needs all of the following:
  - `sel_n` is sampled low for at least MIN_PULSE consecutive rising edges.
  - `prog_pwr`=1, `gate_n`=1 and `id_hv`=0 hold throughout the pulse.
  - At the end, `sel_n` is sampled high while `prog_pwr`=1, `gate_n`=1 and `id_hv`=0.

  When these hold, the word at the address taken at the first low edge becomes old AND the data taken at that same edge, at the edge where `sel_n` is sampled high.
- R6: A pulse shorter than MIN_PULSE edges changes no word. So does a pulse that ends with `gate_n` low, with `prog_pwr` low, or with `id_hv` high.
- R7: Programming only clears bits. A 1 in the write data leaves the stored bit as it is, and a programmed 0 never returns to 1 through programming.
- R8: `erase` high at a rising edge sets every word to 0xFF and cancels a pulse in progress. Erase takes priority over a commit at the same edge.
- R9: Identify mode is `id_hv`=1, `sel_n`=0, `gate_n`=0 and `prog_pwr`=0. In identify mode `q_drive`=1 and `q_data` is 0x20 when `addr[0]`=0 and 0x41 when `addr[0]`=1. All other address bits are ignored.
- R10: Two combinations are illegal: `prog_pwr`=1 with `id_hv`=1, and `prog_pwr`=1 with `sel_n`=0 and `gate_n`=0. Both force `q_drive`=0, and neither starts a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select; its low periods are program pulses |
| gate_n | input | 1 | Active-low output gate |
| prog_pwr | input | 1 | Programming supply present |
| id_hv | input | 1 | Identification high voltage present on an address line |
| addr | input | ADDR_W | Word address; depth is 2**ADDR_W |
| wdata | input | 8 | Byte to program |
| erase | input | 1 | Synchronous erase of the whole array to 0xFF |
| q_data | output | 8 | Read data, 0x00 when not driven |
| q_drive | output | 1 | High when the data bus would be driven |

## Verification
The hardest situations to reach are pulses that sit exactly at the MIN_PULSE boundary, and pulses whose end condition goes wrong just as `sel_n` rises. These need `sel_n` held low for a counted number of edges while the other three control pins are moved at chosen cycles. The stimulus therefore drives each pulse from a task that takes the edge count and the pin values to present at release. It runs lengths of MIN_PULSE-1 and MIN_PULSE, and releases with the gate low, with the supply gone and with an erase at the commit edge. A behavioural model in the bench follows every edge and compares both outputs on every cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MD_READ,
        MD_OFF,
        MD_STANDBY,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT,
        MD_IDENT,
        MD_ILLEGAL
    } mode_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_COUNT,
        PS_READY
    } pulse_t;

    localparam logic [7:0] ID_MAKER  = 8'h20;
    localparam logic [7:0] ID_DEVICE = 8'h41;
    localparam logic [7:0] ERASED    = 8'hFF;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic  sel_n,
    input  logic  gate_n,
    input  logic  prog_pwr,
    input  logic  id_hv,
    output mode_t mode
);

    always_comb begin
        if (prog_pwr) begin
            if (id_hv) begin
                mode = MD_ILLEGAL;
            end else begin
                unique case ({sel_n, gate_n})
                    2'b01:   mode = MD_PROGRAM;
                    2'b10:   mode = MD_VERIFY;
                    2'b11:   mode = MD_INHIBIT;
                    default: mode = MD_ILLEGAL;
                endcase
            end
        end else if (sel_n) begin
            mode = MD_STANDBY;
        end else if (gate_n) begin
            mode = MD_OFF;
        end else if (id_hv) begin
            mode = MD_IDENT;
        end else begin
            mode = MD_READ;
        end
    end

endmodule

// File: rtl/otp_pulse_fsm.sv
module otp_pulse_fsm
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int MIN_PULSE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              sel_n,
    input  logic              gate_n,
    input  logic              prog_pwr,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PULSE - 1);

    pulse_t            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] a_q, a_d;
    logic [7:0]        d_q, d_d;
    logic              pulse_on, release_ok;

    assign pulse_on   = prog_pwr && gate_n && !sel_n && !id_hv;
    assign release_ok = prog_pwr && gate_n && sel_n && !id_hv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
            a_q     <= '0;
            d_q     <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            a_q     <= a_d;
            d_q     <= d_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        a_d     = a_q;
        d_d     = d_q;
        unique case (state_q)
            PS_IDLE: begin
                if (pulse_on) begin
                    a_d     = addr;
                    d_d     = wdata;
                    cnt_d   = CNT_W'(1);
                    state_d = (MIN_PULSE <= 1) ? PS_READY : PS_COUNT;
                end
            end
            PS_COUNT: begin
                if (pulse_on) begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == CNT_LAST) state_d = PS_READY;
                end else begin
                    state_d = PS_IDLE;
                end
            end
            PS_READY: begin
                if (!pulse_on) state_d = PS_IDLE;
            end
            default: state_d = PS_IDLE;
        endcase
        if (erase) state_d = PS_IDLE;
    end

    always_comb begin
        wr_en   = (state_q == PS_READY) && release_ok && !erase;
        wr_addr = a_q;
        wr_data = d_q;
    end

    a_r5_write_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sel_n && $past(!sel_n)));

    a_r10_no_pulse_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_IDLE && prog_pwr && id_hv) |=> (state_q == PS_IDLE));

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
        end else if (wr_en) begin
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        a_r7_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            !erase |=> ((cells[g] & ~$past(cells[g])) == 8'h00));
        a_r8_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
            erase |=> (cells[g] == ERASED));
    end

endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int MIN_PULSE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              gate_n,
    input  logic              prog_pwr,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              erase,
    output logic [7:0]        q_data,
    output logic              q_drive
);

    mode_t             mode;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [7:0]        word;

    otp_mode_decode u_decode (
        .sel_n    (sel_n),
        .gate_n   (gate_n),
        .prog_pwr (prog_pwr),
        .id_hv    (id_hv),
        .mode     (mode)
    );

    otp_pulse_fsm #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase    (erase),
        .sel_n    (sel_n),
        .gate_n   (gate_n),
        .prog_pwr (prog_pwr),
        .id_hv    (id_hv),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    otp_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase    (erase),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (addr),
        .rd_data  (word)
    );

    always_comb begin
        q_drive = 1'b0;
        q_data  = 8'h00;
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                q_drive = 1'b1;
                q_data  = word;
            end
            MD_IDENT: begin
                q_drive = 1'b1;
                q_data  = addr[0] ? ID_DEVICE : ID_MAKER;
            end
            MD_OFF, MD_STANDBY, MD_PROGRAM, MD_INHIBIT, MD_ILLEGAL: begin
                q_drive = 1'b0;
                q_data  = 8'h00;
            end
            default: begin
                q_drive = 1'b0;
                q_data  = 8'h00;
            end
        endcase
    end

    a_r3_standby_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_pwr && (sel_n || gate_n)) |-> (!q_drive && q_data == 8'h00));

    a_r10_illegal_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_pwr && (id_hv || (!sel_n && !gate_n))) |-> !q_drive);

    a_r4_verify_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_pwr && !id_hv && sel_n && !gate_n) |-> q_drive);

    a_r9_ident_code: assert property (@(posedge clk) disable iff (!rst_n)
        (id_hv && !prog_pwr && !sel_n && !gate_n) |->
            (q_drive && q_data == (addr[0] ? 8'h41 : 8'h20)));

endmodule

// File: tb/test_otp_byte_store.sv
module test_otp_byte_store;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int MIN_PULSE  = 4;
    localparam int DEPTH      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_n = 1'b1, gate_n = 1'b1, prog_pwr = 1'b0, id_hv = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = 8'hFF;
    logic              erase = 1'b0;
    logic [7:0]        q_data;
    logic              q_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    otp_byte_store #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) i_otp_byte_store (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .gate_n(gate_n),
        .prog_pwr(prog_pwr), .id_hv(id_hv), .addr(addr), .wdata(wdata),
        .erase(erase), .q_data(q_data), .q_drive(q_drive)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference model
    logic [7:0]        m_mem [DEPTH];
    int                m_low;
    logic [ADDR_W-1:0] m_a;
    logic [7:0]        m_d;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
            m_low = 0;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
            m_low = 0;
        end else if (prog_pwr && gate_n && !sel_n && !id_hv) begin
            if (m_low == 0) begin
                m_a = addr;
                m_d = wdata;
            end
            m_low = m_low + 1;
        end else begin
            if (m_low >= MIN_PULSE && prog_pwr && gate_n && sel_n && !id_hv)
                m_mem[m_a] = m_mem[m_a] & m_d;
            m_low = 0;
        end
    end

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual drive/data=%0b/%02h expected %0b/%02h",
                     tag, act[8], act[7:0], exp[8], exp[7:0]);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [8:0] e;
            string      t;
            if (prog_pwr && (id_hv || (!sel_n && !gate_n))) begin
                e = 9'h000; t = "R10";
            end else if (prog_pwr) begin
                e = (sel_n && !gate_n) ? {1'b1, m_mem[addr]} : 9'h000; t = "R4";
            end else if (sel_n || gate_n) begin
                e = 9'h000; t = "R3";
            end else if (id_hv) begin
                e = {1'b1, addr[0] ? 8'h41 : 8'h20}; t = "R9";
            end else begin
                e = {1'b1, m_mem[addr]}; t = "R2";
            end
            chk(t, {q_drive, q_data}, e);
        end
    end

    task automatic idle_pins();
        sel_n = 1'b1; gate_n = 1'b1; prog_pwr = 1'b0; id_hv = 1'b0; erase = 1'b0;
    endtask

    task automatic read_word(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        idle_pins();
        addr = a; sel_n = 1'b0; gate_n = 1'b0;
        #2;
        chk(tag, {q_drive, q_data}, {1'b1, exp});
    endtask

    // rel: 0 clean release, 1 gate low at release, 2 supply gone, 3 erase at commit edge
    task automatic pulse(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int edges, input int rel);
        @(negedge clk);
        idle_pins();
        prog_pwr = 1'b1; addr = a; wdata = d; sel_n = 1'b0;
        repeat (edges) @(negedge clk);
        addr = ~a; wdata = 8'h00;
        sel_n = 1'b1;
        if (rel == 1) gate_n = 1'b0;
        if (rel == 2) prog_pwr = 1'b0;
        if (rel == 3) erase = 1'b1;
        @(negedge clk);
        idle_pins();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk("R1 standby after reset", {q_drive, q_data}, 9'h000);
        for (int i = 0; i < DEPTH; i++) read_word(ADDR_W'(i), 8'hFF, "R1 erased after reset");

        pulse(4'd3, 8'hA5, MIN_PULSE, 0);
        read_word(4'd3, 8'hA5, "R5 program at minimum length");
        read_word(4'd12, 8'hFF, "R5 latched address only");
        pulse(4'd3, 8'h0F, MIN_PULSE + 3, 0);
        read_word(4'd3, 8'h05, "R7 AND with old value");
        pulse(4'd3, 8'hFF, MIN_PULSE, 0);
        read_word(4'd3, 8'h05, "R7 ones leave bits");

        pulse(4'd5, 8'h00, MIN_PULSE - 1, 0);
        read_word(4'd5, 8'hFF, "R6 short pulse");
        pulse(4'd5, 8'h00, MIN_PULSE, 1);
        read_word(4'd5, 8'hFF, "R6 gate low at release");
        pulse(4'd5, 8'h00, MIN_PULSE, 2);
        read_word(4'd5, 8'hFF, "R6 supply gone at release");

        @(negedge clk);
        idle_pins(); prog_pwr = 1'b1; gate_n = 1'b0; addr = 4'd3;
        #2;
        chk("R4 verify", {q_drive, q_data}, {1'b1, 8'h05});
        gate_n = 1'b1;
        #1;
        chk("R4 inhibit", {q_drive, q_data}, 9'h000);

        @(negedge clk);
        idle_pins(); sel_n = 1'b0; gate_n = 1'b0; id_hv = 1'b1; addr = 4'd0;
        #2;
        chk("R9 maker byte", {q_drive, q_data}, {1'b1, 8'h20});
        addr = 4'd1;
        #1;
        chk("R9 device byte", {q_drive, q_data}, {1'b1, 8'h41});
        addr = 4'hE;
        #1;
        chk("R9 upper bits ignored", {q_drive, q_data}, {1'b1, 8'h20});
        prog_pwr = 1'b1; gate_n = 1'b1;
        repeat (MIN_PULSE + 1) @(negedge clk);
        sel_n = 1'b1;
        @(negedge clk);
        idle_pins();
        read_word(4'hE, 8'hFF, "R10 no program with id voltage");

        @(negedge clk);
        idle_pins(); sel_n = 1'b0; gate_n = 1'b0; prog_pwr = 1'b1; addr = 4'd3;
        #2;
        chk("R10 both low with supply", {q_drive, q_data}, 9'h000);
        @(negedge clk);
        idle_pins(); sel_n = 1'b1; gate_n = 1'b0; addr = 4'd3;
        #2;
        chk("R3 standby ignores gate", {q_drive, q_data}, 9'h000);
        sel_n = 1'b0; gate_n = 1'b1;
        #1;
        chk("R3 output off", {q_drive, q_data}, 9'h000);

        pulse(4'd7, 8'h00, MIN_PULSE, 3);
        read_word(4'd7, 8'hFF, "R8 erase beats commit");
        read_word(4'd3, 8'hFF, "R8 erase restores ones");
        pulse(4'd9, 8'h3C, MIN_PULSE, 0);
        read_word(4'd9, 8'h3C, "R2 read after program");
        @(negedge clk);
        idle_pins(); erase = 1'b1;
        @(negedge clk);
        idle_pins();
        read_word(4'd9, 8'hFF, "R8 erase");

        @(negedge clk);
        idle_pins();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule